// File: doc/BRIEF.md
# Plug-and-Play Configuration Port Controller

This block is the device-side register front end of a legacy plug-and-play configuration space on an 8-bit I/O bus. Two consecutive I/O addresses belong to it. The lower address is the index port and takes a register number. The upper address is the data port and reads or writes the register that the index names. Register access stays locked until software writes a two-byte key to the index port. A separate exit byte locks it again.

Behind the ports sit a global device-selector register and one register bank for each logical device. Each bank holds an enable bit and two 16-bit I/O base values, and every 16-bit value is split across two byte registers. The bank contents drive the per-device enable and base outputs straight from registers, so the peripherals downstream see a new setting on the clock edge that stores it. The bus side uses plain single-cycle strobes. The controller never stalls a write. A read strobe always produces exactly one `rd_valid` pulse one cycle later, so no back-pressure exists in either direction.

Top module: `siocfg_port`

## Requirements
- R1: The controller unlocks only after two consecutive index-port writes of 0x87. Data-port accesses between the two key bytes do not count as index writes.
- R2: While locked, an index-port write of any value other than 0x87 after a first 0x87 resets the key detector, so a full pair of 0x87 writes is needed again.
- R3: While unlocked, an index-port write of 0xAA locks the controller and leaves the index register unchanged.
- R4: While locked, data-port reads return 0xFF, data-port writes change no register, and index-port writes other than the key do not load the index register.
- R5: While unlocked, an index-port write (other than 0xAA) loads the index register. The index register keeps its value across any number of data-port accesses.
- R6: Register 0x07 is the device selector. A write stores bits 3:0, and a read returns {4'h0, selector}.
- R7: Register 0x30 of the selected device is its enable. A write stores bit 0, and a read returns {7'h0, enable}.
- R8: Registers 0x60 (high byte) and 0x61 (low byte) of the selected device form its first 16-bit I/O base, output on `dev_base_a`.
- R9: Registers 0x62 (high byte) and 0x63 (low byte) of the selected device form its second 16-bit I/O base, output on `dev_base_b`.
- R10: Reset clears the lock state, the index register, the selector, every enable and every base, as well as `rd_valid` and `rd_data`.
- R11: Reads of any unimplemented register number return 0x00. Writes to such a register change nothing. The same holds for a selector value at or above NDEV.
- R12: A data-port write changes the device outputs on the next rising clock edge. A data-port read strobe gives `rd_valid` high with `rd_data` on the following cycle, and `rd_valid` is low in every other cycle.
- R13: A per-device register write affects only the bank that the selector names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | I/O address of the current access |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a data-port read strobe |
| rd_data | output | 8 | Read data |
| dev_en | output | NDEV | Enable bit of each logical device |
| dev_base_a | output | NDEV*16 | First I/O base of each device, device g at bits [16g+15:16g] |
| dev_base_b | output | NDEV*16 | Second I/O base of each device, same packing |

## Verification
Every register update, key-state change and device-output change lands on the rising edge that samples the strobe. Read data lands one edge after the read strobe. The bench drives each strobe at a falling edge for one full cycle and samples on the next falling edge, which places every check exactly one edge after its stimulus. It checks the full set of device outputs after each write, and it checks `rd_valid` and `rd_data` after each read against a reference model that the bench updates at the same point.

// File: rtl/siocfg_pkg.sv
package siocfg_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned MAX_DEV = 1 << SEL_W;
  localparam int unsigned BASE_W  = 2 * DATA_W;

  localparam logic [DATA_W-1:0] KEY_OPEN  = 8'h87;
  localparam logic [DATA_W-1:0] KEY_CLOSE = 8'hAA;
  localparam logic [DATA_W-1:0] RD_LOCKED = 8'hFF;

  localparam logic [DATA_W-1:0] REG_SEL    = 8'h07;
  localparam logic [DATA_W-1:0] REG_ENA    = 8'h30;
  localparam logic [DATA_W-1:0] REG_A_HIGH = 8'h60;
  localparam logic [DATA_W-1:0] REG_A_LOW  = 8'h61;
  localparam logic [DATA_W-1:0] REG_B_HIGH = 8'h62;
  localparam logic [DATA_W-1:0] REG_B_LOW  = 8'h63;

  typedef enum logic [1:0] {
    MODE_LOCKED = 2'd0,
    MODE_HALF   = 2'd1,
    MODE_OPEN   = 2'd2
  } mode_t;

  typedef struct packed {
    logic              en;
    logic [BASE_W-1:0] base_a;
    logic [BASE_W-1:0] base_b;
  } bank_t;
endpackage

// File: rtl/siocfg_bus_decode.sv
module siocfg_bus_decode #(
  parameter int unsigned          ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]    CFG_PORT = 16'h002E
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              idx_wr,
  output logic              dat_wr,
  output logic              dat_rd
);
  localparam logic [ADDR_W-1:0] DATA_PORT = CFG_PORT + ADDR_W'(1);

  logic hit_idx, hit_dat;

  always_comb begin
    hit_idx = (bus_addr == CFG_PORT);
    hit_dat = (bus_addr == DATA_PORT);
    idx_wr  = bus_wr & hit_idx;
    dat_wr  = bus_wr & hit_dat;
    dat_rd  = bus_rd & hit_dat;
  end
endmodule

// File: rtl/siocfg_mode_ctl.sv
module siocfg_mode_ctl
  import siocfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked,
  output logic [DATA_W-1:0] cur_index
);
  mode_t mode_q, mode_d;
  logic  load_index;

  always_comb begin
    mode_d     = mode_q;
    load_index = 1'b0;
    if (idx_wr) begin
      unique case (mode_q)
        MODE_LOCKED: mode_d = (wdata == KEY_OPEN) ? MODE_HALF : MODE_LOCKED;
        MODE_HALF:   mode_d = (wdata == KEY_OPEN) ? MODE_OPEN : MODE_LOCKED;
        MODE_OPEN: begin
          if (wdata == KEY_CLOSE) mode_d = MODE_LOCKED;
          else                    load_index = 1'b1;
        end
        default:     mode_d = MODE_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_LOCKED;
      cur_index <= '0;
    end else begin
      mode_q <= mode_d;
      if (load_index) cur_index <= wdata;
    end
  end

  assign unlocked = (mode_q == MODE_OPEN);
endmodule

// File: rtl/siocfg_dev_bank.sv
module siocfg_dev_bank
  import siocfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] reg_num,
  input  logic [DATA_W-1:0] wdata,
  output bank_t             bank,
  output logic [DATA_W-1:0] rd_byte
);
  bank_t bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (wr_en) begin
      unique case (reg_num)
        REG_ENA:    bank_q.en                      <= wdata[0];
        REG_A_HIGH: bank_q.base_a[BASE_W-1:DATA_W] <= wdata;
        REG_A_LOW:  bank_q.base_a[DATA_W-1:0]      <= wdata;
        REG_B_HIGH: bank_q.base_b[BASE_W-1:DATA_W] <= wdata;
        REG_B_LOW:  bank_q.base_b[DATA_W-1:0]      <= wdata;
        default:    ;
      endcase
    end
  end

  always_comb begin
    unique case (reg_num)
      REG_ENA:    rd_byte = {{(DATA_W-1){1'b0}}, bank_q.en};
      REG_A_HIGH: rd_byte = bank_q.base_a[BASE_W-1:DATA_W];
      REG_A_LOW:  rd_byte = bank_q.base_a[DATA_W-1:0];
      REG_B_HIGH: rd_byte = bank_q.base_b[BASE_W-1:DATA_W];
      REG_B_LOW:  rd_byte = bank_q.base_b[DATA_W-1:0];
      default:    rd_byte = '0;
    endcase
  end

  assign bank = bank_q;
endmodule

// File: rtl/siocfg_port.sv
module siocfg_port
  import siocfg_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CFG_PORT = 16'h002E,
  parameter int unsigned       NDEV     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic [NDEV-1:0]          dev_en,
  output logic [NDEV*BASE_W-1:0]   dev_base_a,
  output logic [NDEV*BASE_W-1:0]   dev_base_b
);
  localparam int unsigned PAD_W = DATA_W - SEL_W;

  logic              idx_wr, dat_wr, dat_rd;
  logic              cfg_unlocked;
  logic [DATA_W-1:0] cfg_index;
  logic [SEL_W-1:0]  dev_sel;
  logic [DATA_W-1:0] bank_rd [MAX_DEV];
  logic [DATA_W-1:0] rd_next;
  logic              bank_wr_ok;

  siocfg_bus_decode #(.ADDR_W(ADDR_W), .CFG_PORT(CFG_PORT)) u_decode (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .idx_wr   (idx_wr),
    .dat_wr   (dat_wr),
    .dat_rd   (dat_rd)
  );

  siocfg_mode_ctl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (idx_wr),
    .wdata     (bus_wdata),
    .unlocked  (cfg_unlocked),
    .cur_index (cfg_index)
  );

  // Selector register: global, not banked.
  always_ff @(posedge clk) begin
    if (!rst_n)                                          dev_sel <= '0;
    else if (dat_wr && cfg_unlocked && cfg_index == REG_SEL) dev_sel <= bus_wdata[SEL_W-1:0];
  end

  assign bank_wr_ok = dat_wr & cfg_unlocked & (cfg_index != REG_SEL);

  for (genvar g = 0; g < MAX_DEV; g++) begin : g_dev
    if (g < NDEV) begin : g_real
      bank_t bank;
      siocfg_dev_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_wr_ok && dev_sel == SEL_W'(g)),
        .reg_num (cfg_index),
        .wdata   (bus_wdata),
        .bank    (bank),
        .rd_byte (bank_rd[g])
      );
      assign dev_en[g]                       = bank.en;
      assign dev_base_a[g*BASE_W +: BASE_W]  = bank.base_a;
      assign dev_base_b[g*BASE_W +: BASE_W]  = bank.base_b;
    end else begin : g_absent
      assign bank_rd[g] = '0;
    end
  end

  always_comb begin
    if (!cfg_unlocked)           rd_next = RD_LOCKED;
    else if (cfg_index == REG_SEL) rd_next = {{PAD_W{1'b0}}, dev_sel};
    else                         rd_next = bank_rd[dev_sel];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= dat_rd;
      if (dat_rd) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/siocfg_port_chk.sv
module siocfg_port_chk
  import siocfg_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CFG_PORT = 16'h002E,
  parameter int unsigned       NDEV     = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   bus_wr,
  input logic                   bus_rd,
  input logic [DATA_W-1:0]      bus_wdata,
  input logic                   rd_valid,
  input logic [DATA_W-1:0]      rd_data,
  input logic [NDEV-1:0]        dev_en,
  input logic [NDEV*BASE_W-1:0] dev_base_a,
  input logic [NDEV*BASE_W-1:0] dev_base_b,
  input logic                   unlocked
);
  logic i_wr, d_wr, d_rd;
  assign i_wr = bus_wr && (bus_addr == CFG_PORT);
  assign d_wr = bus_wr && (bus_addr == CFG_PORT + ADDR_W'(1));
  assign d_rd = bus_rd && (bus_addr == CFG_PORT + ADDR_W'(1));

  assert_rd_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    d_rd |=> rd_valid);
  assert_rd_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !d_rd |=> !rd_valid);
  assert_locked_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rd && !unlocked) |=> (rd_data == RD_LOCKED));
  assert_locked_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (d_wr && !unlocked) |=> ($stable(dev_en) && $stable(dev_base_a) && $stable(dev_base_b)));
  assert_exit_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && i_wr && bus_wdata == KEY_CLOSE) |=> !unlocked);
  assert_unlock_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(i_wr && bus_wdata == KEY_OPEN));
  assert_out_by_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(dev_en) && $stable(dev_base_a) && $stable(dev_base_b))
      |-> $past(d_wr && unlocked));
endmodule

bind siocfg_port siocfg_port_chk #(.ADDR_W(ADDR_W), .CFG_PORT(CFG_PORT), .NDEV(NDEV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .dev_en     (dev_en),
  .dev_base_a (dev_base_a),
  .dev_base_b (dev_base_b),
  .unlocked   (cfg_unlocked)
);

// File: tb/siocfg_port_bench.sv
`timescale 1ns/1ps
module siocfg_port_bench;
  localparam int unsigned ADDR_W = 16;
  localparam logic [15:0] IDX = 16'h002E;
  localparam logic [15:0] DAT = 16'h002F;
  localparam int unsigned NDEV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic [NDEV-1:0] dev_en;
  logic [NDEV*16-1:0] dev_base_a, dev_base_b;

  always #2.5 clk = ~clk;

  siocfg_port #(.ADDR_W(ADDR_W), .CFG_PORT(IDX), .NDEV(NDEV)) u_siocfg_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .dev_en(dev_en),
    .dev_base_a(dev_base_a), .dev_base_b(dev_base_b)
  );

  int tests = 0, fails = 0;
  bit m_unl = 0, m_half = 0;
  logic [7:0] m_idx = 0;
  logic [3:0] m_sel = 0;
  logic m_en [NDEV];
  logic [15:0] m_ba [NDEV], m_bb [NDEV];

  function automatic logic [7:0] exp_read();
    if (!m_unl) return 8'hFF;
    case (m_idx)
      8'h07: return {4'h0, m_sel};
      8'h30: return {7'h0, m_en[m_sel]};
      8'h60: return m_ba[m_sel][15:8];
      8'h61: return m_ba[m_sel][7:0];
      8'h62: return m_bb[m_sel][15:8];
      8'h63: return m_bb[m_sel][7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req);
    bit ok = 1;
    for (int g = 0; g < NDEV; g++) begin
      if (dev_en[g] !== m_en[g] || dev_base_a[g*16 +: 16] !== m_ba[g] ||
          dev_base_b[g*16 +: 16] !== m_bb[g]) begin
        ok = 0;
        $display("FAIL %s dev%0d actual en=%b a=%h b=%h expected en=%b a=%h b=%h", req, g,
                 dev_en[g], dev_base_a[g*16 +: 16], dev_base_b[g*16 +: 16], m_en[g], m_ba[g], m_bb[g]);
      end
    end
    tests++;
    if (!ok) fails++;
  endtask

  task automatic wr_idx(input logic [7:0] d);
    @(negedge clk); bus_addr = IDX; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    if (m_unl) begin
      if (d == 8'hAA) m_unl = 0; else m_idx = d;
    end else if (m_half) begin
      m_half = 0;
      if (d == 8'h87) m_unl = 1;
    end else if (d == 8'h87) m_half = 1;
  endtask

  task automatic wr_dat(input logic [7:0] d, input string req);
    @(negedge clk); bus_addr = DAT; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    if (m_unl) begin
      case (m_idx)
        8'h07: m_sel = d[3:0];
        8'h30: m_en[m_sel] = d[0];
        8'h60: m_ba[m_sel][15:8] = d;
        8'h61: m_ba[m_sel][7:0] = d;
        8'h62: m_bb[m_sel][15:8] = d;
        8'h63: m_bb[m_sel][7:0] = d;
        default: ;
      endcase
    end
    check_outs(req);
  endtask

  task automatic rd_dat(input string req);
    logic [7:0] e;
    e = exp_read();
    @(negedge clk); bus_addr = DAT; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    check(rd_valid === 1'b1, {req, " rd_valid"}, 32'(rd_valid), 32'd1);
    check(rd_data === e, req, 32'(rd_data), 32'(e));
    @(negedge clk);
    check(rd_valid === 1'b0, "R12 rd_valid single", 32'(rd_valid), 32'd0);
  endtask

  task automatic set_reg(input logic [7:0] r, input logic [7:0] d, input string req);
    wr_idx(r);
    wr_dat(d, req);
  endtask

  initial begin
    #(5ns * 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] regs [6] = '{8'h07, 8'h30, 8'h60, 8'h61, 8'h62, 8'h63};
    void'($urandom(32'h5EED));
    for (int g = 0; g < NDEV; g++) begin m_en[g] = 0; m_ba[g] = 0; m_bb[g] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check_outs("R10");
    check(rd_valid === 1'b0 && rd_data === 8'h00, "R10 read port", {23'h0, rd_valid, rd_data}, 32'h0);
    // R4 locked behaviour
    rd_dat("R4 locked read");
    wr_idx(8'h30);
    wr_dat(8'h01, "R4 locked write");
    // R2 broken key, then R1 unlock
    wr_idx(8'h87); wr_idx(8'h11); wr_idx(8'h87);
    rd_dat("R2 still locked");
    wr_idx(8'h87);
    // data accesses between key bytes do not count
    wr_idx(8'hAA);
    wr_idx(8'h87); wr_dat(8'h55, "R1 data between keys"); wr_idx(8'h87);
    rd_dat("R1 unlocked, index kept at 0 -> R11");
    // R6 selector
    set_reg(8'h07, 8'h35, "R6 write");
    rd_dat("R6 read low nibble");
    // R7 enable
    set_reg(8'h30, 8'hFE, "R7 bit0 clear");
    set_reg(8'h30, 8'hFF, "R7 enable dev5 R12");
    rd_dat("R7 read");
    // R8 and R9 bases
    set_reg(8'h60, 8'h12, "R8 high"); set_reg(8'h61, 8'h34, "R8 low");
    set_reg(8'h62, 8'hAB, "R9 high"); set_reg(8'h63, 8'hCD, "R9 low");
    check(dev_base_a[5*16 +: 16] === 16'h1234, "R8 base a", 32'(dev_base_a[5*16 +: 16]), 32'h1234);
    check(dev_base_b[5*16 +: 16] === 16'hABCD, "R9 base b", 32'(dev_base_b[5*16 +: 16]), 32'hABCD);
    // R5 index held across data accesses
    wr_idx(8'h61);
    wr_dat(8'h56, "R5 first"); wr_dat(8'h78, "R5 second");
    rd_dat("R5 read 1"); rd_dat("R5 read 2");
    // R13 other device
    set_reg(8'h07, 8'h09, "R13 select 9");
    set_reg(8'h30, 8'h01, "R13 enable 9 only");
    set_reg(8'h60, 8'hEE, "R13 base 9");
    // R11 unimplemented register
    set_reg(8'h40, 8'h99, "R11 write ignored");
    rd_dat("R11 read zero");
    // R3 exit
    wr_idx(8'hAA);
    rd_dat("R3 locked after exit");
    wr_dat(8'h00, "R3 write ignored after exit");
    wr_idx(8'h87); wr_idx(8'h87);
    wr_idx(8'h40);
    wr_idx(8'hAA); wr_idx(8'h87); wr_idx(8'h87);
    rd_dat("R3 index unchanged by exit");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      int unsigned op;
      op = $urandom % 16;
      case (op)
        0, 1, 2, 3: wr_idx(regs[$urandom % 6]);
        4, 5, 6, 7, 8: wr_dat(8'($urandom), "R13 random write");
        9, 10, 11: rd_dat("R12 random read");
        12: wr_idx(8'h87);
        13: if ($urandom % 4 == 0) wr_idx(8'hAA); else wr_idx(8'h87);
        14: wr_idx(8'($urandom));
        default: begin wr_idx(8'h07); wr_dat(8'($urandom), "R6 random select"); end
      endcase
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule